// File: doc/BRIEF.md
# Programmable Interrupt Routing Matrix

This block connects four internal peripheral interrupt requests (two serial ports, A and B, and two parallel ports, A and B) to four external interrupt pins, named here by the system interrupt numbers they normally serve: IRQ3, IRQ4, IRQ5 and IRQ7. Each pin has a 2-bit source code. The code picks one peripheral from that pin's own menu, or leaves the pin undriven. The menus differ from pin to pin, and some codes on each pin are reserved as "undriven".

Each pin also has its own polarity bit. When a pin is driven, its output value is the request of the selected peripheral, inverted when the polarity bit is 0. A pin whose selected peripheral is disabled or powered down has its output-enable low, as does an unassigned pin. In that state the value output is held at 0.

The pin outputs are registered once on the system clock. Any change on the inputs therefore appears at the pins one cycle later. The routing byte and the polarity bits come from configuration registers that lie outside this block.

Top module: `irq_route_matrix`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every bit of `irq_oe` and of `irq_val` is 0.
- R2: IRQ3 (pin index 0) takes its code from `route_cfg[7:6]`. Code 10 selects serial A, code 11 selects serial B, and codes 00 and 01 leave the pin undriven.
- R3: IRQ4 (pin index 1) takes its code from `route_cfg[5:4]`. Its menu is the same as that of IRQ3.
- R4: IRQ7 (pin index 3) takes its code from `route_cfg[3:2]`. Code 00 is undriven, 01 selects serial A, 10 selects parallel A and 11 selects parallel B.
- R5: IRQ5 (pin index 2) takes its code from `route_cfg[1:0]`. Code 00 is undriven, 01 selects serial B, 10 selects parallel A and 11 selects parallel B.
- R6: For a driven pin p, `irq_val[p]` equals the selected request when `pol_cfg[p]` is 1, and equals its inverse when `pol_cfg[p]` is 0.
- R7: A pin whose selected peripheral has its `per_en` bit at 0 has `irq_oe` low. Peripheral indices are 0 for serial A, 1 for serial B, 2 for parallel A and 3 for parallel B.
- R8: When several pins select the same peripheral, every one of them carries that peripheral's request, with no arbitration between them.
- R9: The outputs reflect the inputs sampled at the previous rising clock edge. A change on an input is not visible before the next edge.
- R10: Whenever `irq_oe[p]` is 0, `irq_val[p]` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| route_cfg | input | 8 | Source codes for all pins (field positions given in R2 to R5) |
| pol_cfg | input | 4 | Polarity per pin index; 1 means active high |
| per_req | input | 4 | Peripheral interrupt requests, in peripheral index order |
| per_en | input | 4 | Peripheral enabled and powered up, in peripheral index order |
| irq_val | output | 4 | Registered pin values, in pin index order (IRQ3, IRQ4, IRQ5, IRQ7) |
| irq_oe | output | 4 | Registered pin output-enables, in pin index order |

## Verification
The first sweep covers every routing byte, every polarity nibble and every request pattern, with all peripherals enabled. It separates the four pin menus from one another, catches codes that are swapped or misplaced within a field, and catches any inversion error. The second sweep covers every routing byte against every enable pattern, with all requests high and then all requests low. It tells a disabled source apart from an unassigned code, and it also shows when the enable of the wrong peripheral is gating a pin. Directed cases then check two things: a peripheral shared by three pins, and the one-cycle latency, which is checked by sampling once before the clock edge that follows an input change and once after it.

// File: rtl/irq_route_pkg.sv
// Package: shared sizes, peripheral indices and per-pin menu/field helpers
// for the interrupt routing matrix. Pin index order is IRQ3, IRQ4, IRQ5, IRQ7.
package irq_route_pkg;
    localparam int NUM_PINS = 4;
    localparam int NUM_SRC  = 4;
    localparam int SEL_W    = 2;
    localparam int CFG_W    = NUM_PINS * SEL_W;

    // Peripheral indices
    localparam int SRC_SER_A = 0;
    localparam int SRC_SER_B = 1;
    localparam int SRC_PAR_A = 2;
    localparam int SRC_PAR_B = 3;

    // Menu kinds
    localparam int MENU_SERIAL = 0;  // 10 -> ser A, 11 -> ser B, else none
    localparam int MENU_PAR_SA = 1;  // 01 -> ser A, 10 -> par A, 11 -> par B
    localparam int MENU_PAR_SB = 2;  // 01 -> ser B, 10 -> par A, 11 -> par B

    // Least significant bit of each pin's source field in the routing byte
    function automatic int pin_field_lsb(input int pin);
        case (pin)
            0:       return 6;
            1:       return 4;
            2:       return 0;
            default: return 2;
        endcase
    endfunction

    // Menu kind used by each pin
    function automatic int pin_menu(input int pin);
        case (pin)
            0, 1:    return MENU_SERIAL;
            2:       return MENU_PAR_SB;
            default: return MENU_PAR_SA;
        endcase
    endfunction
endpackage

// File: rtl/irq_src_decode.sv
// Module: irq_src_decode
// Turns one pin's source code into a one-hot peripheral pick and a valid flag.
// Assumes MENU is one of the package menu kinds; reserved codes give valid=0.
module irq_src_decode
    import irq_route_pkg::*;
#(
    parameter int MENU  = MENU_SERIAL,
    parameter int SW    = SEL_W,
    parameter int NSRC  = NUM_SRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SW-1:0]   code,
    output logic [NSRC-1:0] pick,
    output logic            valid
);
    // Decode the code against this pin's menu
    always_comb begin
        pick = '0;
        if (MENU == MENU_SERIAL) begin
            case (code)
                2'b10:   pick[SRC_SER_A] = 1'b1;
                2'b11:   pick[SRC_SER_B] = 1'b1;
                default: pick = '0;
            endcase
        end else begin
            case (code)
                2'b01:   pick[(MENU == MENU_PAR_SA) ? SRC_SER_A : SRC_SER_B] = 1'b1;
                2'b10:   pick[SRC_PAR_A] = 1'b1;
                2'b11:   pick[SRC_PAR_B] = 1'b1;
                default: pick = '0;
            endcase
        end
    end

    // Valid whenever any peripheral was picked
    always_comb valid = |pick;

    // R8 (single pick per pin; sharing happens only across pins)
    pick_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick));

    // R2
    code_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code == '0) |-> !valid);
endmodule

// File: rtl/irq_pin_stage.sv
// Module: irq_pin_stage
// Gates one pin's picked request by the peripheral enable, applies polarity
// and registers the pin value and output-enable. Value is 0 when not driven.
module irq_pin_stage #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pick,
    input  logic            valid,
    input  logic            pol,
    input  logic [NSRC-1:0] per_req,
    input  logic [NSRC-1:0] per_en,
    output logic            val_q,
    output logic            oe_q
);
    logic src_on;
    logic src_req;
    logic nxt_oe;
    logic nxt_val;

    // Select the picked peripheral's enable and request
    always_comb begin
        src_on  = |(pick & per_en);
        src_req = |(pick & per_req);
        nxt_oe  = valid & src_on;
        nxt_val = nxt_oe & (src_req ^ ~pol);
    end

    // Register the pin outputs; cleared by synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            val_q <= nxt_val;
            oe_q  <= nxt_oe;
        end
    end

    // R10
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_q |-> !val_q);
endmodule

// File: rtl/irq_route_matrix.sv
// Module: irq_route_matrix (top)
// Routes four peripheral requests onto four pins by per-pin source codes and
// polarity bits. Outputs are registered one cycle after the inputs.
// Assumes configuration inputs come from registers outside this block.
module irq_route_matrix
    import irq_route_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CFG_W-1:0]    route_cfg,
    input  logic [NUM_PINS-1:0] pol_cfg,
    input  logic [NUM_SRC-1:0]  per_req,
    input  logic [NUM_SRC-1:0]  per_en,
    output logic [NUM_PINS-1:0] irq_val,
    output logic [NUM_PINS-1:0] irq_oe
);
    logic [NUM_SRC-1:0] pick [NUM_PINS];
    logic [NUM_PINS-1:0] pin_valid;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int LSB = pin_field_lsb(p);

        irq_src_decode #(
            .MENU (pin_menu(p)),
            .SW   (SEL_W),
            .NSRC (NUM_SRC)
        ) dec_i (
            .clk   (clk),
            .rst_n (rst_n),
            .code  (route_cfg[LSB +: SEL_W]),
            .pick  (pick[p]),
            .valid (pin_valid[p])
        );

        irq_pin_stage #(
            .NSRC (NUM_SRC)
        ) stage_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .pick    (pick[p]),
            .valid   (pin_valid[p]),
            .pol     (pol_cfg[p]),
            .per_req (per_req),
            .per_en  (per_en),
            .val_q   (irq_val[p]),
            .oe_q    (irq_oe[p])
        );

        // R7
        src_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_oe[p] |-> $past(|(pick[p] & per_en)));

        // R6
        pol_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_oe[p] && $past(pol_cfg[p])) |-> (irq_val[p] == $past(|(pick[p] & per_req))));

        // R6
        pol_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_oe[p] && !$past(pol_cfg[p])) |-> (irq_val[p] != $past(|(pick[p] & per_req))));
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (irq_oe == '0 && irq_val == '0));

    // R8
    shared_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_oe[0] && irq_oe[1] && $past(pick[0] == pick[1] && pol_cfg[0] == pol_cfg[1]))
            |-> (irq_val[0] == irq_val[1]));
endmodule

// File: tb/irq_route_matrix_tb.sv
`timescale 1ns/100ps
module irq_route_matrix_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] route_cfg = '0;
    logic [3:0] pol_cfg = '0;
    logic [3:0] per_req = '0;
    logic [3:0] per_en = '0;
    logic [3:0] irq_val;
    logic [3:0] irq_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    irq_route_matrix dut_i (
        .clk(clk), .rst_n(rst_n), .route_cfg(route_cfg), .pol_cfg(pol_cfg),
        .per_req(per_req), .per_en(per_en), .irq_val(irq_val), .irq_oe(irq_oe)
    );

    always #2.5 clk = ~clk;

    // Requirement model: source chosen by pin and code, -1 means undriven
    function automatic int exp_src(input int pin, input logic [1:0] c);
        if (pin <= 1) return (c == 2'b10) ? 0 : (c == 2'b11) ? 1 : -1;
        if (c == 2'b00) return -1;
        if (c == 2'b01) return (pin == 2) ? 1 : 0;
        return (c == 2'b10) ? 2 : 3;
    endfunction

    function automatic int field_lsb(input int pin);
        return (pin == 0) ? 6 : (pin == 1) ? 4 : (pin == 2) ? 0 : 2;
    endfunction

    function automatic string pin_tag(input int pin);
        return (pin == 0) ? "R2" : (pin == 1) ? "R3" : (pin == 2) ? "R5" : "R4";
    endfunction

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b (route=%h pol=%h req=%h en=%h)",
                     tag, what, act, exp, route_cfg, pol_cfg, per_req, per_en);
        end
    endtask

    // Apply a vector at edge+1, sample outputs one edge later at edge+1
    task automatic run_vec(input logic [7:0] r, input logic [3:0] pl,
                           input logic [3:0] rq, input logic [3:0] en);
        route_cfg = r; pol_cfg = pl; per_req = rq; per_en = en;
        @(posedge clk); #1;
        for (int p = 0; p < 4; p++) begin
            int s;
            logic eo, ev;
            string to, tv;
            s  = exp_src(p, r[field_lsb(p) +: 2]);
            eo = (s >= 0) && en[s];
            ev = eo ? (rq[s] ~^ pl[p]) : 1'b0;
            to = (s >= 0 && !en[s]) ? "R7" : pin_tag(p);
            tv = !eo ? "R10" : (!pl[p] ? "R6" : pin_tag(p));
            check(to, $sformatf("oe[%0d]", p), irq_oe[p], eo);
            check(tv, $sformatf("val[%0d]", p), irq_val[p], ev);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs quiet during reset
        check("R1", "oe in reset", |irq_oe, 1'b0);
        route_cfg = 8'hFF; pol_cfg = 4'h0; per_req = 4'hF; per_en = 4'hF;
        rst_n = 1'b1;
        // R1: first cycle after reset still quiet
        check("R1", "oe after reset", |irq_oe, 1'b0);
        check("R1", "val after reset", |irq_val, 1'b0);

        // Sweep 1: every routing byte, polarity and request, all enabled
        for (int r = 0; r < 256; r++)
            for (int pl = 0; pl < 16; pl++)
                for (int rq = 0; rq < 16; rq++)
                    run_vec(r[7:0], pl[3:0], rq[3:0], 4'hF);

        // Sweep 2: every routing byte and enable pattern, requests all high/low
        for (int r = 0; r < 256; r++)
            for (int en = 0; en < 16; en++) begin
                run_vec(r[7:0], 4'hF, 4'hF, en[3:0]);
                run_vec(r[7:0], 4'h5, 4'h0, en[3:0]);
            end

        // R8: IRQ3, IRQ4 and IRQ7 share serial A
        run_vec(8'hA5, 4'hF, 4'h1, 4'hF);
        check("R8", "irq3 shared", irq_val[0], 1'b1);
        check("R8", "irq4 shared", irq_val[1], 1'b1);
        check("R8", "irq7 shared", irq_val[3], 1'b1);

        // R9: change is not visible before the next edge
        run_vec(8'hA5, 4'hF, 4'h0, 4'hF);
        per_req = 4'h1;
        #1;
        check("R9", "before edge", irq_val[0], 1'b0);
        @(posedge clk); #1;
        check("R9", "after edge", irq_val[0], 1'b1);
        pol_cfg = 4'h0;
        #1;
        check("R9", "pol before edge", irq_val[0], 1'b1);
        @(posedge clk); #1;
        check("R9", "pol after edge", irq_val[0], 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule